// File: doc/BRIEF.md
# Configurable register / latch storage cell

This block is a WIDTH-bit storage cell whose behaviour is fixed at elaboration. In edge mode it is a register that captures on the transition of its clock into the active level. In latch mode it has no clock and acts as a level-sensitive latch opened by its load strobe. In global-clock mode it copies D on every active clock edge and ignores every other control. Each optional control can be left out, and each control that is present has its own active level.

The controls are resolved in a fixed order of precedence, with each bit treated on its own. The per-bit clear vector comes first, then the per-bit set vector, then asynchronous reset, then asynchronous load, then synchronous reset, then clock enable, and D last. A mode parameter decides whether an inactive enable also blocks the synchronous reset.

Inside each bit there is a two-state selector with states SRC_CLOCKED and SRC_ASYNC. It records which path wrote the bit most recently. The transition to SRC_ASYNC happens at once when any asynchronous control of that bit becomes active. The transition back to SRC_CLOCKED happens on the first active clock edge at which that bit has no asynchronous control active. In latch mode the selector stays in SRC_ASYNC.

Top module: `ffl_cell`

## Requirements
- R1: In edge mode, Q changes only when the clock moves from its inactive level to its active level, as set by CLK_POL (1 = rising edge, 0 = falling edge). With enable active and synchronous reset inactive, Q then takes the D sampled at that edge.
- R2: When enable is inactive at an active clock edge, and the synchronous reset is not active (or is gated by enable), Q keeps its value.
- R3: With EN_OVER_SRST=0, a synchronous reset that is active at an edge loads SRST_VAL, whatever the enable level.
- R4: With EN_OVER_SRST=1, a synchronous reset is ignored when enable is inactive, and Q holds. When enable is active, the synchronous reset loads SRST_VAL.
- R5: While asynchronous load is active, each bit not under set, clear or async reset follows AD_I at once. After the load is released, the bit keeps the last AD value until the next edge or asynchronous event.
- R6: In latch mode the clock has no effect. Q follows AD_I while load is active and holds while load is inactive.
- R7: While asynchronous reset is active, each bit not under set or clear equals ARST_VAL. Asynchronous reset outranks asynchronous load and clocked updates.
- R8: An active clear bit forces its Q bit to 0 and an active set bit forces its Q bit to 1. Clear wins over set, and both outrank every other control.
- R9: Every control's polarity parameter (1 = active-high, 0 = active-low) selects its active level independently of the others.
- R10: In global-clock mode, Q takes D at every active clock edge, and enable, resets, load, set and clear have no effect.
- R11: With no asynchronous control active and no active clock edge, Q is unchanged, including when D or AD change.
- R12: A control whose presence parameter is 0 has no effect on Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock (edge and global-clock modes) |
| en_i | input | 1 | Clock enable |
| srst_i | input | 1 | Synchronous reset |
| arst_i | input | 1 | Asynchronous reset |
| aload_i | input | 1 | Asynchronous load / latch open strobe |
| ad_i | input | WIDTH | Asynchronous load data |
| set_i | input | WIDTH | Per-bit asynchronous set |
| clr_i | input | WIDTH | Per-bit asynchronous clear |
| d_i | input | WIDTH | Clocked data |
| q_o | output | WIDTH | Stored value |

## Verification
The bench drives five cells from one logical stimulus: active-high edge mode; active-low with a falling-edge clock and enable gating reset; latch; global-clock; and a cell with every control absent. It sweeps every combination of enable, sync reset, async load and async reset, and overlaps them with mixed set and clear vectors. A cell with the wrong precedence would show the value of the lower-ranked control on the bits where two controls meet, for example set instead of clear, or load data during reset. A cell that forgot the value left by a released async load would fall back to a stale clocked value. A cell with the enable-over-reset option reversed would reset when it should hold.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

    typedef enum logic [1:0] {
        FFL_EDGE  = 2'd0,
        FFL_LATCH = 2'd1,
        FFL_GCLK  = 2'd2
    } ffl_mode_e;

    typedef enum logic {
        SRC_CLOCKED = 1'b0,
        SRC_ASYNC   = 1'b1
    } ffl_src_e;

endpackage

// File: rtl/ffl_async_path.sv
module ffl_async_path #(
    parameter int               WIDTH      = 4,
    parameter bit               HAS_ARST   = 1'b1,
    parameter bit               HAS_ALOAD  = 1'b1,
    parameter bit               HAS_SETCLR = 1'b1,
    parameter bit               ARST_POL   = 1'b1,
    parameter bit               ALOAD_POL  = 1'b1,
    parameter bit               SET_POL    = 1'b1,
    parameter bit               CLR_POL    = 1'b1,
    parameter logic [WIDTH-1:0] ARST_VAL   = '0
) (
    input  logic             arst_i,
    input  logic             aload_i,
    input  logic [WIDTH-1:0] ad_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] any_o,
    output logic [WIDTH-1:0] val_o
);

    logic arst_act;
    logic aload_act;

    assign arst_act  = HAS_ARST  && (arst_i  == ARST_POL);
    assign aload_act = HAS_ALOAD && (aload_i == ALOAD_POL);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic clr_act;
        logic set_act;

        assign clr_act = HAS_SETCLR && (clr_i[b] == CLR_POL);
        assign set_act = HAS_SETCLR && (set_i[b] == SET_POL);

        always_comb begin
            if (clr_act) begin
                val_o[b] = 1'b0;
            end else if (set_act) begin
                val_o[b] = 1'b1;
            end else if (arst_act) begin
                val_o[b] = ARST_VAL[b];
            end else begin
                val_o[b] = ad_i[b];
            end
            any_o[b] = clr_act | set_act | arst_act | aload_act;
        end
    end

endmodule

// File: rtl/ffl_sync_next.sv
module ffl_sync_next #(
    parameter int               WIDTH        = 4,
    parameter bit               HAS_EN       = 1'b1,
    parameter bit               HAS_SRST     = 1'b1,
    parameter bit               EN_POL       = 1'b1,
    parameter bit               SRST_POL     = 1'b1,
    parameter bit               EN_OVER_SRST = 1'b0,
    parameter logic [WIDTH-1:0] SRST_VAL     = '0
) (
    input  logic             en_i,
    input  logic             srst_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] next_o
);

    logic en_act;
    logic srst_act;

    assign en_act   = !HAS_EN || (en_i == EN_POL);
    assign srst_act = HAS_SRST && (srst_i == SRST_POL);

    always_comb begin
        if (EN_OVER_SRST && !en_act) begin
            next_o = cur_i;
        end else if (srst_act) begin
            next_o = SRST_VAL;
        end else if (en_act) begin
            next_o = d_i;
        end else begin
            next_o = cur_i;
        end
    end

endmodule

// File: rtl/ffl_bit_store.sv
module ffl_bit_store
    import ffl_pkg::*;
#(
    parameter ffl_mode_e MODE    = FFL_EDGE,
    parameter bit        CLK_POL = 1'b1
) (
    input  logic clk_i,
    input  logic async_any_i,
    input  logic async_val_i,
    input  logic next_i,
    output logic q_o
);

    if (MODE == FFL_EDGE) begin : g_edge
        ffl_src_e src_q;
        logic     reg_q;
        logic     ovr_q;

        if (CLK_POL) begin : g_rise
            always_ff @(posedge clk_i or posedge async_any_i) begin
                if (async_any_i) begin
                    src_q <= SRC_ASYNC;
                end else begin
                    src_q <= SRC_CLOCKED;
                end
            end
            always_ff @(posedge clk_i) begin
                reg_q <= next_i;
            end
        end else begin : g_fall
            always_ff @(negedge clk_i or posedge async_any_i) begin
                if (async_any_i) begin
                    src_q <= SRC_ASYNC;
                end else begin
                    src_q <= SRC_CLOCKED;
                end
            end
            always_ff @(negedge clk_i) begin
                reg_q <= next_i;
            end
        end

        always_latch begin
            if (async_any_i) begin
                ovr_q <= async_val_i;
            end
        end

        always_comb begin
            unique case (src_q)
                SRC_ASYNC:   q_o = async_any_i ? async_val_i : ovr_q;
                SRC_CLOCKED: q_o = async_any_i ? async_val_i : reg_q;
                default:     q_o = reg_q;
            endcase
        end
    end else if (MODE == FFL_LATCH) begin : g_latch
        logic ovr_q;

        always_latch begin
            if (async_any_i) begin
                ovr_q <= async_val_i;
            end
        end

        assign q_o = async_any_i ? async_val_i : ovr_q;
    end else begin : g_gclk
        logic reg_q;

        if (CLK_POL) begin : g_rise
            always_ff @(posedge clk_i) begin
                reg_q <= next_i;
            end
        end else begin : g_fall
            always_ff @(negedge clk_i) begin
                reg_q <= next_i;
            end
        end

        assign q_o = reg_q;
    end

endmodule

// File: rtl/ffl_cell.sv
module ffl_cell
    import ffl_pkg::*;
#(
    parameter int               WIDTH        = 4,
    parameter ffl_mode_e        MODE         = FFL_EDGE,
    parameter bit               HAS_EN       = 1'b1,
    parameter bit               HAS_SRST     = 1'b1,
    parameter bit               HAS_ALOAD    = 1'b1,
    parameter bit               HAS_ARST     = 1'b1,
    parameter bit               HAS_SETCLR   = 1'b1,
    parameter bit               CLK_POL      = 1'b1,
    parameter bit               EN_POL       = 1'b1,
    parameter bit               SRST_POL     = 1'b1,
    parameter bit               ALOAD_POL    = 1'b1,
    parameter bit               ARST_POL     = 1'b1,
    parameter bit               SET_POL      = 1'b1,
    parameter bit               CLR_POL      = 1'b1,
    parameter bit               EN_OVER_SRST = 1'b0,
    parameter logic [WIDTH-1:0] SRST_VAL     = '0,
    parameter logic [WIDTH-1:0] ARST_VAL     = '0
) (
    input  logic             clk_i,
    input  logic             en_i,
    input  logic             srst_i,
    input  logic             arst_i,
    input  logic             aload_i,
    input  logic [WIDTH-1:0] ad_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam bit IS_GCLK = (MODE == FFL_GCLK);

    logic [WIDTH-1:0] async_any;
    logic [WIDTH-1:0] async_val;
    logic [WIDTH-1:0] sync_next;
    logic [WIDTH-1:0] store_any;
    logic [WIDTH-1:0] store_next;
    logic [WIDTH-1:0] q_int;

    ffl_async_path #(
        .WIDTH     (WIDTH),
        .HAS_ARST  (HAS_ARST),
        .HAS_ALOAD (HAS_ALOAD),
        .HAS_SETCLR(HAS_SETCLR),
        .ARST_POL  (ARST_POL),
        .ALOAD_POL (ALOAD_POL),
        .SET_POL   (SET_POL),
        .CLR_POL   (CLR_POL),
        .ARST_VAL  (ARST_VAL)
    ) u_async (
        .arst_i (arst_i),
        .aload_i(aload_i),
        .ad_i   (ad_i),
        .set_i  (set_i),
        .clr_i  (clr_i),
        .any_o  (async_any),
        .val_o  (async_val)
    );

    ffl_sync_next #(
        .WIDTH       (WIDTH),
        .HAS_EN      (HAS_EN),
        .HAS_SRST    (HAS_SRST),
        .EN_POL      (EN_POL),
        .SRST_POL    (SRST_POL),
        .EN_OVER_SRST(EN_OVER_SRST),
        .SRST_VAL    (SRST_VAL)
    ) u_sync (
        .en_i  (en_i),
        .srst_i(srst_i),
        .d_i   (d_i),
        .cur_i (q_int),
        .next_o(sync_next)
    );

    if (IS_GCLK) begin : g_gclk_sel
        assign store_any  = '0;
        assign store_next = d_i;
    end else begin : g_ctrl_sel
        assign store_any  = async_any;
        assign store_next = sync_next;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_store
        ffl_bit_store #(
            .MODE   (MODE),
            .CLK_POL(CLK_POL)
        ) u_bit (
            .clk_i      (clk_i),
            .async_any_i(store_any[b]),
            .async_val_i(async_val[b]),
            .next_i     (store_next[b]),
            .q_o        (q_int[b])
        );
    end

    assign q_o = q_int;

endmodule

// File: rtl/ffl_cell_chk.sv
module ffl_cell_chk
    import ffl_pkg::*;
#(
    parameter int               WIDTH        = 4,
    parameter ffl_mode_e        MODE         = FFL_EDGE,
    parameter bit               HAS_EN       = 1'b1,
    parameter bit               HAS_SRST     = 1'b1,
    parameter bit               HAS_ALOAD    = 1'b1,
    parameter bit               HAS_ARST     = 1'b1,
    parameter bit               HAS_SETCLR   = 1'b1,
    parameter bit               CLK_POL      = 1'b1,
    parameter bit               EN_POL       = 1'b1,
    parameter bit               SRST_POL     = 1'b1,
    parameter bit               ALOAD_POL    = 1'b1,
    parameter bit               ARST_POL     = 1'b1,
    parameter bit               SET_POL      = 1'b1,
    parameter bit               CLR_POL      = 1'b1,
    parameter bit               EN_OVER_SRST = 1'b0,
    parameter logic [WIDTH-1:0] SRST_VAL     = '0,
    parameter logic [WIDTH-1:0] ARST_VAL     = '0
) (
    input logic             clk_i,
    input logic             en_i,
    input logic             srst_i,
    input logic             arst_i,
    input logic             aload_i,
    input logic [WIDTH-1:0] ad_i,
    input logic [WIDTH-1:0] set_i,
    input logic [WIDTH-1:0] clr_i,
    input logic [WIDTH-1:0] d_i,
    input logic [WIDTH-1:0] q_o
);

    localparam bit IS_EDGE = (MODE == FFL_EDGE);
    localparam bit IS_GCLK = (MODE == FFL_GCLK);

    logic             cap_clk;
    logic             armed_q = 1'b0;
    logic             en_a;
    logic             sr_a;
    logic             ar_a;
    logic             al_a;
    logic [WIDTH-1:0] set_a;
    logic [WIDTH-1:0] clr_a;
    logic             any_a;

    assign cap_clk = CLK_POL ? clk_i : ~clk_i;
    assign en_a    = !HAS_EN || (en_i == EN_POL);
    assign sr_a    = HAS_SRST && (srst_i == SRST_POL);
    assign ar_a    = !IS_GCLK && HAS_ARST && (arst_i == ARST_POL);
    assign al_a    = !IS_GCLK && HAS_ALOAD && (aload_i == ALOAD_POL);
    assign set_a   = (!IS_GCLK && HAS_SETCLR) ? ~(set_i ^ {WIDTH{SET_POL}}) : '0;
    assign clr_a   = (!IS_GCLK && HAS_SETCLR) ? ~(clr_i ^ {WIDTH{CLR_POL}}) : '0;
    assign any_a   = ar_a | al_a | (|set_a) | (|clr_a);

    always_ff @(posedge cap_clk) begin
        armed_q <= 1'b1;
    end

    AST_CLR_FORCES_ZERO: assert property (@(posedge cap_clk) disable iff (!armed_q)
        ((q_o & clr_a) == '0)); // R8

    AST_SET_FORCES_ONE: assert property (@(posedge cap_clk) disable iff (!armed_q)
        ((~q_o & set_a & ~clr_a) == '0)); // R8

    AST_ARST_VALUE: assert property (@(posedge cap_clk) disable iff (!armed_q)
        ar_a |-> (((q_o ^ ARST_VAL) & ~(set_a | clr_a)) == '0)); // R7

    AST_ALOAD_FOLLOWS: assert property (@(posedge cap_clk) disable iff (!armed_q)
        (al_a && !ar_a) |-> (((q_o ^ ad_i) & ~(set_a | clr_a)) == '0)); // R5

    AST_SRST_LOADS: assert property (@(posedge cap_clk) disable iff (!armed_q)
        (IS_EDGE && sr_a && (!EN_OVER_SRST || en_a) && !any_a)
        |=> (any_a || (q_o == SRST_VAL))); // R3

    AST_EN_BLOCKS: assert property (@(posedge cap_clk) disable iff (!armed_q)
        (IS_EDGE && !en_a && (EN_OVER_SRST || !sr_a) && !any_a)
        |=> (any_a || $stable(q_o))); // R2

    AST_D_CAPTURE: assert property (@(posedge cap_clk) disable iff (!armed_q)
        (IS_EDGE && en_a && !sr_a && !any_a)
        |=> (any_a || (q_o == $past(d_i)))); // R1

    AST_GCLK_TRACKS: assert property (@(posedge cap_clk) disable iff (!armed_q)
        IS_GCLK |=> (q_o == $past(d_i))); // R10

endmodule

bind ffl_cell ffl_cell_chk #(
    .WIDTH       (WIDTH),
    .MODE        (MODE),
    .HAS_EN      (HAS_EN),
    .HAS_SRST    (HAS_SRST),
    .HAS_ALOAD   (HAS_ALOAD),
    .HAS_ARST    (HAS_ARST),
    .HAS_SETCLR  (HAS_SETCLR),
    .CLK_POL     (CLK_POL),
    .EN_POL      (EN_POL),
    .SRST_POL    (SRST_POL),
    .ALOAD_POL   (ALOAD_POL),
    .ARST_POL    (ARST_POL),
    .SET_POL     (SET_POL),
    .CLR_POL     (CLR_POL),
    .EN_OVER_SRST(EN_OVER_SRST),
    .SRST_VAL    (SRST_VAL),
    .ARST_VAL    (ARST_VAL)
) u_chk (
    .clk_i  (clk_i),
    .en_i   (en_i),
    .srst_i (srst_i),
    .arst_i (arst_i),
    .aload_i(aload_i),
    .ad_i   (ad_i),
    .set_i  (set_i),
    .clr_i  (clr_i),
    .d_i    (d_i),
    .q_o    (q_o)
);

// File: tb/ffl_cell_tb.sv
module ffl_cell_tb;
    import ffl_pkg::*;

    localparam int CLK_P  = 10;
    localparam int W      = 4;
    localparam int NCYC   = 1024;
    localparam logic [W-1:0] M_SRV = 4'hA;
    localparam logic [W-1:0] M_ARV = 4'h5;
    localparam logic [W-1:0] E_SRV = 4'h3;
    localparam logic [W-1:0] E_ARV = 4'hC;
    localparam logic [W-1:0] L_ARV = 4'h9;

    logic clk = 1'b0;
    logic en, sr, ar, al;
    logic [W-1:0] d, ad, setv, clrv;
    logic [W-1:0] q_main, q_eos, q_lat, q_gck, q_bare;
    logic [W-1:0] m_main, m_eos, m_lat, m_gck, m_bare;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    // Active-high rising-edge cell, sync reset wins over enable
    ffl_cell #(.WIDTH(W), .SRST_VAL(M_SRV), .ARST_VAL(M_ARV)) u_dut (
        .clk_i(clk), .en_i(en), .srst_i(sr), .arst_i(ar), .aload_i(al),
        .ad_i(ad), .set_i(setv), .clr_i(clrv), .d_i(d), .q_o(q_main));

    // All controls active-low, falling-edge clock, enable gates sync reset
    ffl_cell #(.WIDTH(W), .CLK_POL(1'b0), .EN_POL(1'b0), .SRST_POL(1'b0),
               .ALOAD_POL(1'b0), .ARST_POL(1'b0), .SET_POL(1'b0), .CLR_POL(1'b0),
               .EN_OVER_SRST(1'b1), .SRST_VAL(E_SRV), .ARST_VAL(E_ARV)) u_dut_eos (
        .clk_i(~clk), .en_i(~en), .srst_i(~sr), .arst_i(~ar), .aload_i(~al),
        .ad_i(ad), .set_i(~setv), .clr_i(~clrv), .d_i(d), .q_o(q_eos));

    ffl_cell #(.WIDTH(W), .MODE(FFL_LATCH), .HAS_EN(1'b0), .HAS_SRST(1'b0),
               .ARST_VAL(L_ARV)) u_dut_lat (
        .clk_i(clk), .en_i(en), .srst_i(sr), .arst_i(ar), .aload_i(al),
        .ad_i(ad), .set_i(setv), .clr_i(clrv), .d_i(d), .q_o(q_lat));

    ffl_cell #(.WIDTH(W), .MODE(FFL_GCLK), .SRST_VAL(M_SRV), .ARST_VAL(M_ARV)) u_dut_gck (
        .clk_i(clk), .en_i(en), .srst_i(sr), .arst_i(ar), .aload_i(al),
        .ad_i(ad), .set_i(setv), .clr_i(clrv), .d_i(d), .q_o(q_gck));

    ffl_cell #(.WIDTH(W), .HAS_EN(1'b0), .HAS_SRST(1'b0), .HAS_ALOAD(1'b0),
               .HAS_ARST(1'b0), .HAS_SETCLR(1'b0), .SRST_VAL(M_SRV), .ARST_VAL(M_ARV)) u_dut_bare (
        .clk_i(clk), .en_i(en), .srst_i(sr), .arst_i(ar), .aload_i(al),
        .ad_i(ad), .set_i(setv), .clr_i(clrv), .d_i(d), .q_o(q_bare));

    function automatic logic [W-1:0] amask(bit has_ar, bit has_al, bit has_sc);
        logic [W-1:0] m;
        for (int b = 0; b < W; b++) begin
            m[b] = (has_sc && (clrv[b] || setv[b])) || (has_ar && ar) || (has_al && al);
        end
        return m;
    endfunction

    function automatic logic [W-1:0] async_apply(logic [W-1:0] cur, bit has_ar, bit has_al,
                                                  bit has_sc, logic [W-1:0] arv);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            if (has_sc && clrv[b])      r[b] = 1'b0;
            else if (has_sc && setv[b]) r[b] = 1'b1;
            else if (has_ar && ar)      r[b] = arv[b];
            else if (has_al && al)      r[b] = ad[b];
            else                        r[b] = cur[b];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] sync_apply(logic [W-1:0] cur, bit eos, logic [W-1:0] srv,
                                                 logic [W-1:0] msk);
        logic [W-1:0] nxt;
        if (eos && !en)  nxt = cur;
        else if (sr)     nxt = srv;
        else if (en)     nxt = d;
        else             nxt = cur;
        return (nxt & ~msk) | (cur & msk);
    endfunction

    function automatic string edge_tag(bit eos);
        if (|clrv || |setv) return eos ? "R9/R8" : "R8";
        if (ar)             return eos ? "R9/R7" : "R7";
        if (al)             return eos ? "R9/R5" : "R5";
        if (eos)            return "R4";
        if (sr)             return "R3";
        if (!en)            return "R2";
        return "R1";
    endfunction

    task automatic chk(string tag, string who, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: q=%h expected=%h at %0t", tag, who, act, exp, $time);
        end
    endtask

    task automatic async_models();
        m_main = async_apply(m_main, 1'b1, 1'b1, 1'b1, M_ARV);
        m_eos  = async_apply(m_eos,  1'b1, 1'b1, 1'b1, E_ARV);
        m_lat  = async_apply(m_lat,  1'b1, 1'b1, 1'b1, L_ARV);
    endtask

    task automatic check_all(bit after_edge);
        bit quiet;
        quiet = (amask(1'b1, 1'b1, 1'b1) == '0);
        chk((!after_edge && quiet) ? "R11" : edge_tag(1'b0), "main", q_main, m_main);
        chk(edge_tag(1'b1), "eos", q_eos, m_eos);
        chk("R6", "latch", q_lat, m_lat);
        chk("R10", "gclk", q_gck, m_gck);
        chk("R12", "bare", q_bare, m_bare);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_err++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    end

    initial begin
        en = 0; sr = 0; ar = 1; al = 1; d = '0; ad = '0; setv = '0; clrv = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        m_main = M_ARV; m_eos = E_ARV; m_lat = L_ARV; m_gck = '0; m_bare = '0;
        chk("R7", "main reset state", q_main, M_ARV);
        chk("R7", "eos reset state", q_eos, E_ARV);
        chk("R7", "latch reset state", q_lat, L_ARV);
        chk("R10", "gclk reset state", q_gck, '0);
        chk("R12", "bare reset state", q_bare, '0);

        for (int i = 0; i < NCYC; i++) begin
            logic [9:0] k;
            k = 10'(i);
            @(negedge clk);
            en   = k[0];
            sr   = k[1];
            al   = k[2] & k[4];
            ar   = k[3] & k[5] & k[6];
            setv = k[7] ? W'(i * 3 + 1) : '0;
            clrv = k[8] & k[9] ? W'(i * 5 + 2) : (k[8] ? W'(i * 5) & 4'h3 : '0);
            #1;
            async_models();
            d  = W'(i * 7 + 3);
            ad = W'(i * 11 + 5);
            #1;
            async_models();
            check_all(1'b0);
            @(posedge clk);
            m_main = sync_apply(m_main, 1'b0, M_SRV, amask(1'b1, 1'b1, 1'b1));
            m_eos  = sync_apply(m_eos,  1'b1, E_SRV, amask(1'b1, 1'b1, 1'b1));
            m_gck  = d;
            m_bare = d;
            #1;
            check_all(1'b1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule